// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter with Line-Driver Keying

This block turns bytes offered on a valid/ready input into asynchronous serial frames on a single output line. The line rests at logic high, and no clock travels with the data. Each frame has one low start bit, then eight data bits with the least significant bit first, then one high stop bit. A 16-bit divisor input sets the bit time, counted in system clock cycles. With a suitable system clock the divisor covers rates from 300 baud to 3 Mbaud.

A separate output keys an RS485 line driver. It rises one full bit time before the first start bit of a burst. It falls one full bit time after the stop bit of the last frame in that burst. The block only begins a new frame while the active-low clear-to-send input is low. A frame that has already begun always runs to its end. The active-low request-to-send output tells the far end when the block could take another byte.

The control is a four-state machine:
- `ST_IDLE`: the line is quiet.
- `ST_LEAD`: the leading guard bit time.
- `ST_SHIFT`: the ten bits of a frame are on the line.
- `ST_TRAIL`: the trailing guard bit time.

Its transitions are:
- IDLE→LEAD when a byte is accepted.
- LEAD→SHIFT when the guard bit time ends.
- SHIFT→SHIFT when a byte is accepted on the last tick of a stop bit.
- SHIFT→TRAIL when the stop bit ends and no byte is accepted.
- TRAIL→SHIFT when a byte is accepted during the guard.
- TRAIL→IDLE when the guard ends unused.

Top module: `serial_tx_keyed`

## Requirements
- R1: While `tx_active` is low, `txd` is high. After reset `txd` is 1 and `tx_active` is 0.
- R2: A frame is a start bit of 0, then eight data bits with bit 0 first, then a stop bit of 1. Each bit lasts D clock cycles, where D equals `baud_div`.
- R3: `tx_active` rises exactly D cycles before the first start bit of a burst begins.
- R4: When no byte follows, `tx_active` falls exactly D cycles after the last stop bit ends.
- R5: A byte accepted on the last cycle of a stop bit, or during the trailing guard, starts its start bit on the next cycle. `tx_active` stays high across such frames.
- R6: While `cts_n` is 1, `in_ready` is 0 and no frame starts from idle.
- R7: A frame already started runs to its end even if `cts_n` goes to 1 during it. After that, no further byte is taken.
- R8: `rts_n` is 0 in the idle and trailing-guard states, and 1 during the leading guard and during frames.
- R9: `in_ready` is 1 only when `cts_n` is 0 and the block is in one of these windows: idle, trailing guard, or the last cycle of a stop bit.
- R10: A `baud_div` of 0 acts as 1, so each bit lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Clock cycles per bit; 0 is treated as 1. Change it only while idle |
| in_data | input | 8 | Byte offered for sending |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Byte is accepted on the clock edge where `in_valid` and `in_ready` are both 1 |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| txd | output | 1 | Serial data; idles high |
| tx_active | output | 1 | RS485 driver enable, with one-bit guards |

## Verification
Several rules are checked every cycle by the assertions:
- The line is high whenever the driver is off.
- The first bit after the leading guard is a start bit, and the stop bit is high.
- The driver enable only drops out of the trailing guard.
- The idle state holds while clear-to-send is high.
- Request-to-send is high during frames.

The bench scenarios cover what a single cycle cannot show. These are the exact guard lengths before and after a burst, and the decoded content and bit timing of each frame at divisors 4, 0 and 7. They also cover back-to-back frames, both from the stop bit and from within the trailing guard. Finally, they cover a clear-to-send withdrawal that lands in the middle of a frame.

// File: rtl/serial_tx_keyed_pkg.sv
package serial_tx_keyed_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } tx_state_e;
endpackage

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             run,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // A divisor of zero behaves as one (R10)
    assign limit = (divisor == '0) ? '0 : divisor - 1'b1;
    assign tick  = run && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !tick) |=> (cnt_q != '0));
endmodule

// File: rtl/serial_tx_shreg.sv
module serial_tx_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              bit_out,
    output logic              last_bit
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   pos_q;

    assign bit_out  = sh_q[0];
    assign last_bit = (pos_q == CNT_W'(FRAME_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '1;
            pos_q <= '0;
        end else if (load) begin
            sh_q  <= {1'b1, din, 1'b0};
            pos_q <= '0;
        end else if (shift) begin
            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
            pos_q <= pos_q + 1'b1;
        end
    end

    // A freshly loaded frame presents its start bit first (R2)
    assert_start_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bit_out == 1'b0));
endmodule

// File: rtl/serial_tx_keyed.sv
module serial_tx_keyed
    import serial_tx_keyed_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cts_n,
    output logic              rts_n,
    output logic              txd,
    output logic              tx_active
);
    tx_state_e state_q, state_d;
    logic      tick, last_bit, bit_out;
    logic      window, accept, shift;

    always_comb begin
        window = (state_q == ST_IDLE) || (state_q == ST_TRAIL) ||
                 ((state_q == ST_SHIFT) && tick && last_bit);
    end
    assign in_ready = window && !cts_n;
    assign accept   = in_valid && in_ready;
    assign shift    = (state_q == ST_SHIFT) && tick;

    serial_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (baud_div),
        .run     (state_q != ST_IDLE),
        .restart (accept),
        .tick    (tick)
    );

    serial_tx_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift    (shift),
        .din      (in_data),
        .bit_out  (bit_out),
        .last_bit (last_bit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && last_bit) state_d = accept ? ST_SHIFT : ST_TRAIL;
            ST_TRAIL: begin
                if (accept) state_d = ST_SHIFT;
                else if (tick) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        txd       = 1'b1;
        tx_active = 1'b1;
        rts_n     = 1'b1;
        unique case (state_q)
            ST_IDLE:  begin tx_active = 1'b0; rts_n = 1'b0; end
            ST_LEAD:  ;
            ST_SHIFT: txd = bit_out;
            ST_TRAIL: rts_n = 1'b0;
            default:  tx_active = 1'b0;
        endcase
    end

    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> txd);
    assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && last_bit) |-> txd);
    assert_lead_to_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && $past(state_q) == ST_LEAD) |-> !txd);
    assert_drop_from_trail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active) |-> $past(state_q) == ST_TRAIL);
    assert_cts_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cts_n) |=> state_q == ST_IDLE);
    assert_rts_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> rts_n);
endmodule

// File: tb/test_serial_tx_keyed.sv
module test_serial_tx_keyed;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd4;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        cts_n = 1'b0;
    logic        rts_n, txd, tx_active;

    int checks = 0;
    int errors = 0;
    int bitd = 4;
    int last_burst = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_tx_keyed i_serial_tx_keyed (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .cts_n(cts_n),
        .rts_n(rts_n), .txd(txd), .tx_active(tx_active)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Driver: offers a byte, waits for acceptance, then pushes it to the scoreboard
    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (tx_active);
        @(negedge clk);
    endtask

    // Monitor: measures guards and decodes frames against the scoreboard
    initial begin
        logic [7:0] got;
        logic       sb, pb;
        int         lead, tr, nfr;
        bit         more;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (!tx_active) begin
                if (!txd) check(1'b0, "R1 idle line", txd, 1);
            end else begin
                lead = 0;
                while (txd && tx_active) begin
                    lead++;
                    @(negedge clk);
                end
                check(lead == bitd, "R3 lead guard", lead, bitd);
                nfr = 0;
                more = 1;
                while (more) begin
                    repeat (bitd / 2) @(negedge clk);
                    sb = txd;
                    for (int i = 0; i < 8; i++) begin
                        repeat (bitd) @(negedge clk);
                        got[i] = txd;
                    end
                    repeat (bitd) @(negedge clk);
                    pb = txd;
                    check(sb == 1'b0 && pb == 1'b1, "R2/R10 framing", {sb, pb}, 1);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected frame", got, -1);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check(got == e, "R2/R10 data", got, e);
                    end
                    nfr++;
                    repeat (bitd - 1 - bitd / 2) @(negedge clk);
                    tr = 0;
                    more = 0;
                    while (1) begin
                        @(negedge clk);
                        if (!tx_active) break;
                        if (!txd) begin more = 1; break; end
                        tr++;
                    end
                    if (!more) check(tr == bitd, "R4 trail guard", tr, bitd);
                end
                last_burst = nfr;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(txd == 1'b1 && tx_active == 1'b0, "R1 reset state", {txd, tx_active}, 2);
        check(rts_n == 1'b0, "R8 rts idle", rts_n, 0);
        check(in_ready == 1'b1, "R9 ready idle", in_ready, 1);
        @(negedge clk);

        // single frame, divisor 4
        send(8'hA5);
        wait_idle();

        // mid-frame request/ready state
        send(8'h3C);
        repeat (bitd * 4) @(negedge clk);
        #1;
        check(rts_n == 1'b1, "R8 rts busy", rts_n, 1);
        check(in_ready == 1'b0, "R9 ready busy", in_ready, 0);
        wait_idle();

        // back-to-back from stop bit
        send(8'h12); send(8'h34); send(8'hF0);
        wait_idle();
        check(last_burst == 3, "R5 burst from stop", last_burst, 3);

        // byte offered inside the trailing guard
        send(8'h6B);
        repeat (11 * bitd) @(negedge clk);
        #1;
        check(rts_n == 1'b0 && in_ready == 1'b1, "R8/R9 trail window", {rts_n, in_ready}, 1);
        send(8'hD4);
        wait_idle();
        check(last_burst == 2, "R5 burst from trail", last_burst, 2);

        // clear-to-send withheld from idle
        cts_n = 1'b1;
        in_valid = 1'b1;
        in_data = 8'h55;
        repeat (40) @(negedge clk);
        #1;
        check(tx_active == 1'b0 && in_ready == 1'b0, "R6 cts gate", {tx_active, in_ready}, 0);
        in_valid = 1'b0;
        cts_n = 1'b0;
        @(negedge clk);
        send(8'h55);
        wait_idle();

        // clear-to-send withdrawn mid-frame
        send(8'hC3);
        repeat (2 * bitd) @(negedge clk);
        cts_n = 1'b1;
        in_valid = 1'b1;
        in_data = 8'h99;
        wait_idle();
        #1;
        check(exp_q.size() == 0, "R7 frame completed", exp_q.size(), 0);
        check(in_ready == 1'b0, "R7 no further byte", in_ready, 0);
        repeat (20) @(negedge clk);
        check(tx_active == 1'b0, "R6 stays idle", tx_active, 0);
        in_valid = 1'b0;
        cts_n = 1'b0;
        @(negedge clk);

        // divisor zero behaves as one
        baud_div = 16'd0;
        bitd = 1;
        @(negedge clk);
        send(8'h01); send(8'h80);
        wait_idle();
        check(last_burst == 2, "R10 divisor zero burst", last_burst, 2);

        // odd divisor
        baud_div = 16'd7;
        bitd = 7;
        @(negedge clk);
        send(8'hFF); send(8'h00);
        wait_idle();
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule